// File: doc/BRIEF.md
# Four-Lane Vector Arithmetic Unit

This block executes vector instructions that combine two source vector registers element by element, by either addition or multiplication. The result goes to a destination vector register. An instruction is presented on an issue handshake together with its opcode, three register indices and an element count. The unit walks the vector four elements per cycle. Element `i` is always handled by lane `i mod 4`, and each lane keeps its own slice of every vector register. Inside a lane, a two-stage adder and a six-stage multiplier both accept a new element every cycle.

Dependencies are checked once per instruction, against a per-register pending mask. An instruction that names a register still awaiting write-back is held until the writer completes. Instructions that are independent overlap: one can read its operands while the previous one is still draining its pipeline. A debug port gives direct, element-indexed access to the register file. Software uses it to load operands and to read results.

Top module: `vec_unit`

## Requirements
- R1: Element `i` of register `r` is addressed by `dbg_reg`=`r` and `dbg_idx`=`i`. It lives in lane `i mod 4`, row `i/4`. `dbg_rdata` returns it combinationally. A `dbg_we` pulse while `busy` is low stores `dbg_wdata` there at the next rising edge.
- R2: `issue_vl` (1 to 32) sets how many elements are processed: elements 0 to `issue_vl`-1 of the destination are written, and higher elements keep their old value.
- R3: With `issue_op`=0 each destination element becomes the sum of the two source elements, modulo 2^32.
- R4: With `issue_op`=1 each destination element becomes the low 32 bits of the product of the two source elements.
- R5: For an instruction accepted without overlap, `done` is high in the cycle that follows rising edge number ceil(vl/4)+S counted after the accepting edge. S is 2 for add and 6 for multiply.
- R6: An instruction whose `issue_vd`, `issue_vs1` or `issue_vs2` names the destination of an instruction not yet done is held with `issue_ready` low. At the earliest it is accepted at the edge that ends the writer's `done` cycle, and its results follow program order.
- R7: A multiply that has no register conflict and follows a one-row instruction is accepted two edges after that instruction's acceptance, before the earlier one is done.
- R8: An add is not accepted while multiply results issued earlier could still reach write-back at or after its own results. After a one-row multiply, the add is accepted no earlier than six edges after it, and both results are intact.
- R9: `done` is high for exactly one cycle per completed instruction. `busy` is high from the acceptance until the last outstanding instruction is done.
- R10: While reset is asserted and right after it is released, `issue_ready` is high and both `busy` and `done` are low.
- R11: A `dbg_we` pulse while `busy` is high is ignored, and the addressed element keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction accepted at this edge when valid |
| issue_op | input | 1 | 0 add, 1 multiply |
| issue_vd | input | 3 | Destination register index |
| issue_vs1 | input | 3 | First source register index |
| issue_vs2 | input | 3 | Second source register index |
| issue_vl | input | 6 | Element count, 1 to 32 |
| busy | output | 1 | An instruction is sequencing or awaiting write-back |
| done | output | 1 | One-cycle pulse when an instruction's last element is written |
| dbg_we | input | 1 | Debug write strobe, honoured only when idle |
| dbg_reg | input | 3 | Debug register index |
| dbg_idx | input | 5 | Debug element index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |

## Verification
Two things can happen in the same cycle: the write-back of an older instruction's trailing elements, and the operand reads of a newer independent instruction in the same lanes. The bench provokes this with back-to-back multiplies and an add behind a multiply, and with long runs of random instructions issued as soon as `issue_ready` allows. Each run is judged by reading every register element through the debug port and comparing it with a program-order model. Acceptance cycles are compared with the interlock and `done` timing rules.

// File: rtl/vec_pkg.sv
`timescale 1ns/1ps
package vec_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } vop_e;
endpackage

// File: rtl/vec_fu_pipe.sv
`timescale 1ns/1ps
// Fully pipelined functional-unit shell: the result enters at stage 0 and
// moves one stage per cycle together with its write-back tag.
module vec_fu_pipe #(
  parameter int W      = 32,
  parameter int TW     = 7,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [TW-1:0] in_tag,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [TW-1:0] out_tag
);
  logic [STAGES-1:0] v_q;
  logic [W-1:0]      d_q [STAGES];
  logic [TW-1:0]     t_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= (v_q << 1) | STAGES'(in_valid);
  end

  // payload registers: no reset, each stage enabled by its upstream valid
  always_ff @(posedge clk) begin
    if (in_valid) begin
      d_q[0] <= in_data;
      t_q[0] <= in_tag;
    end
    for (int s = 1; s < STAGES; s++) begin
      if (v_q[s-1]) begin
        d_q[s] <= d_q[s-1];
        t_q[s] <= t_q[s-1];
      end
    end
  end

  assign out_valid = v_q[STAGES-1];
  assign out_data  = d_q[STAGES-1];
  assign out_tag   = t_q[STAGES-1];
endmodule

// File: rtl/vec_lane.sv
`timescale 1ns/1ps
// One lane: its slice of every vector register plus an adder and a
// multiplier pipeline sharing one write port.
module vec_lane
  import vec_pkg::*;
#(
  parameter int W      = 32,
  parameter int NREGS  = 8,
  parameter int ROWS   = 8,
  parameter int ADD_ST = 2,
  parameter int MUL_ST = 6,
  localparam int RW    = $clog2(ROWS),
  localparam int RIW   = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RW-1:0]  rd_row,
  input  logic [RIW-1:0] rd_vs1,
  input  logic [RIW-1:0] rd_vs2,
  input  logic           el_valid,
  input  logic           el_last,
  input  vop_e           el_op,
  input  logic [RIW-1:0] el_vd,
  input  logic           dbg_we,
  input  logic [RIW-1:0] dbg_reg,
  input  logic [RW-1:0]  dbg_row,
  input  logic [W-1:0]   dbg_wdata,
  output logic [W-1:0]   dbg_rdata,
  output logic           wb_last,
  output logic [RIW-1:0] wb_vd
);
  localparam int AW = RIW + RW;
  localparam int TW = 1 + RIW + RW;

  logic [W-1:0]  rf_q [NREGS*ROWS];
  logic [W-1:0]  opa, opb, sum, prod;
  logic [TW-1:0] tag;
  logic          a_ov, m_ov;
  logic [W-1:0]  a_od, m_od;
  logic [TW-1:0] a_ot, m_ot;
  logic          wb_valid;
  logic [W-1:0]  wb_data;
  logic [TW-1:0] wb_tag;
  logic          we;
  logic [AW-1:0] waddr;
  logic [W-1:0]  wdata;

  // two operand read ports and one debug read port
  assign opa       = rf_q[{rd_vs1, rd_row}];
  assign opb       = rf_q[{rd_vs2, rd_row}];
  assign dbg_rdata = rf_q[{dbg_reg, dbg_row}];

  assign sum  = opa + opb;
  assign prod = opa * opb;
  assign tag  = {el_last, el_vd, rd_row};

  vec_fu_pipe #(.W(W), .TW(TW), .STAGES(ADD_ST)) u_add (
    .clk(clk), .rst_n(rst_n),
    .in_valid(el_valid && (el_op == OP_ADD)), .in_data(sum), .in_tag(tag),
    .out_valid(a_ov), .out_data(a_od), .out_tag(a_ot)
  );

  vec_fu_pipe #(.W(W), .TW(TW), .STAGES(MUL_ST)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .in_valid(el_valid && (el_op == OP_MUL)), .in_data(prod), .in_tag(tag),
    .out_valid(m_ov), .out_data(m_od), .out_tag(m_ot)
  );

  assign wb_valid = a_ov | m_ov;
  assign wb_data  = a_ov ? a_od : m_od;
  assign wb_tag   = a_ov ? a_ot : m_ot;
  assign wb_last  = wb_valid & wb_tag[TW-1];
  assign wb_vd    = wb_tag[TW-2 -: RIW];

  // write-port selection
  always_comb begin
    we    = 1'b0;
    waddr = {dbg_reg, dbg_row};
    wdata = dbg_wdata;
    if (wb_valid) begin
      we    = 1'b1;
      waddr = {wb_vd, wb_tag[RW-1:0]};
      wdata = wb_data;
    end else if (dbg_we) begin
      we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) rf_q[waddr] <= wdata;
  end

  // the issue logic must keep the two pipelines from landing together
  assert_single_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ov && m_ov));

  // debug writes only arrive while nothing is in flight
  assert_dbg_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_we && wb_valid));
endmodule

// File: rtl/vec_seq.sv
`timescale 1ns/1ps
// Issue, element sequencing, per-register pending mask and done pulse.
module vec_seq
  import vec_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NREGS  = 8,
  parameter int MAXVL  = 32,
  parameter int ADD_ST = 2,
  parameter int MUL_ST = 6,
  localparam int LW    = $clog2(LANES),
  localparam int RW    = $clog2(MAXVL / LANES),
  localparam int RIW   = $clog2(NREGS),
  localparam int VLW   = $clog2(MAXVL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_valid,
  input  vop_e                      issue_op,
  input  logic [RIW-1:0]            issue_vd,
  input  logic [RIW-1:0]            issue_vs1,
  input  logic [RIW-1:0]            issue_vs2,
  input  logic [VLW-1:0]            issue_vl,
  output logic                      issue_ready,
  output logic                      busy,
  output logic                      done,
  input  logic [LANES-1:0]          wb_last,
  input  logic [LANES-1:0][RIW-1:0] wb_vd,
  output logic [RW-1:0]             rd_row,
  output logic [RIW-1:0]            rd_vs1,
  output logic [RIW-1:0]            rd_vs2,
  output logic [RIW-1:0]            ex_vd,
  output vop_e                      ex_op,
  output logic [LANES-1:0]          el_valid,
  output logic [LANES-1:0]          el_last
);
  // cycles a multiply result trails an add issued at the same time
  localparam int GAP = MUL_ST - ADD_ST;
  localparam int CW  = $clog2(MUL_ST + 1);

  logic             act_q, act_d;
  logic [RW-1:0]    row_q, row_d;
  vop_e             op_q;
  logic [RIW-1:0]   vd_q, vs1_q, vs2_q;
  logic [VLW-1:0]   vl_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [NREGS-1:0] pend_q, pend_d, clr, set;
  logic             done_q, done_d;
  logic             hazard, struct_stall, accept, last_row;
  logic [VLW-1:0]   base;

  assign base     = VLW'({row_q, {LW{1'b0}}});
  assign last_row = (base + VLW'(LANES)) >= vl_q;

  // once-per-instruction operand check against in-flight destinations
  assign hazard       = pend_q[issue_vd] | pend_q[issue_vs1] | pend_q[issue_vs2];
  assign struct_stall = (issue_op == OP_ADD) && (cnt_q != '0);
  assign issue_ready  = !act_q && !hazard && !struct_stall;
  assign accept       = issue_valid && issue_ready;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      el_valid[l] = act_q && ((base + VLW'(l)) < vl_q);
      el_last[l]  = act_q && ((base + VLW'(l) + VLW'(1)) == vl_q);
    end
  end

  always_comb begin
    clr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (wb_last[l]) clr[wb_vd[l]] = 1'b1;
    end
    set = '0;
    if (accept) set[issue_vd] = 1'b1;
    pend_d = (pend_q & ~clr) | set;
    done_d = |wb_last;

    act_d = act_q;
    row_d = row_q;
    if (act_q) begin
      if (last_row) act_d = 1'b0;
      else          row_d = row_q + RW'(1);
    end
    if (accept) begin
      act_d = 1'b1;
      row_d = '0;
    end

    if (act_q && (op_q == OP_MUL)) cnt_d = CW'(GAP);
    else if (cnt_q != '0)          cnt_d = cnt_q - CW'(1);
    else                           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      pend_q <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  // instruction payload: enabled registers without reset
  always_ff @(posedge clk) begin
    if (act_q || accept) row_q <= row_d;
    if (accept) begin
      op_q  <= issue_op;
      vd_q  <= issue_vd;
      vs1_q <= issue_vs1;
      vs2_q <= issue_vs2;
      vl_q  <= issue_vl;
    end
  end

  assign rd_row = row_q;
  assign rd_vs1 = vs1_q;
  assign rd_vs2 = vs2_q;
  assign ex_vd  = vd_q;
  assign ex_op  = op_q;
  assign busy   = act_q | (|pend_q);
  assign done   = done_q;

  assert_vl_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (issue_vl != '0) && (issue_vl <= VLW'(MAXVL)));

  assert_row_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (base < vl_q));

  assert_done_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(|pend_q));

  for (genvar l = 0; l < LANES; l++) begin : g_own
    assert_wb_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_last[l] |-> pend_q[wb_vd[l]]);
  end
endmodule

// File: rtl/vec_unit.sv
`timescale 1ns/1ps
module vec_unit
  import vec_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NREGS  = 8,
  parameter int MAXVL  = 32,
  parameter int W      = 32,
  parameter int ADD_ST = 2,
  parameter int MUL_ST = 6,
  localparam int LW    = $clog2(LANES),
  localparam int ROWS  = MAXVL / LANES,
  localparam int RW    = $clog2(ROWS),
  localparam int RIW   = $clog2(NREGS),
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int IW    = $clog2(MAXVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_valid,
  output logic           issue_ready,
  input  logic           issue_op,
  input  logic [RIW-1:0] issue_vd,
  input  logic [RIW-1:0] issue_vs1,
  input  logic [RIW-1:0] issue_vs2,
  input  logic [VLW-1:0] issue_vl,
  output logic           busy,
  output logic           done,
  input  logic           dbg_we,
  input  logic [RIW-1:0] dbg_reg,
  input  logic [IW-1:0]  dbg_idx,
  input  logic [W-1:0]   dbg_wdata,
  output logic [W-1:0]   dbg_rdata
);
  logic [RW-1:0]             rd_row;
  logic [RIW-1:0]            rd_vs1, rd_vs2, ex_vd;
  vop_e                      ex_op;
  logic [LANES-1:0]          el_valid, el_last, wb_last;
  logic [LANES-1:0][RIW-1:0] wb_vd;
  logic [W-1:0]              lane_rdata [LANES];
  logic [LW-1:0]             dbg_lane;
  logic [RW-1:0]             dbg_row;
  logic                      dbg_ok;

  assign dbg_lane = dbg_idx[LW-1:0];
  assign dbg_row  = dbg_idx[IW-1:LW];
  assign dbg_ok   = dbg_we && !busy;

  vec_seq #(
    .LANES(LANES), .NREGS(NREGS), .MAXVL(MAXVL),
    .ADD_ST(ADD_ST), .MUL_ST(MUL_ST)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_op(vop_e'(issue_op)),
    .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
    .issue_vl(issue_vl), .issue_ready(issue_ready),
    .busy(busy), .done(done),
    .wb_last(wb_last), .wb_vd(wb_vd),
    .rd_row(rd_row), .rd_vs1(rd_vs1), .rd_vs2(rd_vs2),
    .ex_vd(ex_vd), .ex_op(ex_op),
    .el_valid(el_valid), .el_last(el_last)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vec_lane #(
      .W(W), .NREGS(NREGS), .ROWS(ROWS),
      .ADD_ST(ADD_ST), .MUL_ST(MUL_ST)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .rd_row(rd_row), .rd_vs1(rd_vs1), .rd_vs2(rd_vs2),
      .el_valid(el_valid[l]), .el_last(el_last[l]),
      .el_op(ex_op), .el_vd(ex_vd),
      .dbg_we(dbg_ok && (dbg_lane == LW'(l))),
      .dbg_reg(dbg_reg), .dbg_row(dbg_row), .dbg_wdata(dbg_wdata),
      .dbg_rdata(lane_rdata[l]),
      .wb_last(wb_last[l]), .wb_vd(wb_vd[l])
    );
  end

  assign dbg_rdata = lane_rdata[dbg_lane];
endmodule

// File: tb/tb_vec_unit.sv
`timescale 1ns/1ps
module tb_vec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid, issue_ready, issue_op;
  logic [2:0]  issue_vd, issue_vs1, issue_vs2;
  logic [5:0]  issue_vl;
  logic        busy, done;
  logic        dbg_we;
  logic [2:0]  dbg_reg;
  logic [4:0]  dbg_idx;
  logic [31:0] dbg_wdata, dbg_rdata;

  vec_unit dut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
    .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
    .issue_vl(issue_vl), .busy(busy), .done(done),
    .dbg_we(dbg_we), .dbg_reg(dbg_reg), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] gold [8][32];
  int checks = 0, fails = 0, cyc = 0, ndone = 0, last_done = -1;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n === 1'b1 && done) begin
    ndone     <= ndone + 1;
    last_done <= cyc;
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic logic [31:0] alu(bit op, logic [31:0] a, logic [31:0] b);
    return op ? a * b : a + b;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sync();
    @(negedge clk); #1;
  endtask

  task automatic dwrite(int r, int i, logic [31:0] v);
    dbg_reg = 3'(r); dbg_idx = 5'(i); dbg_wdata = v; dbg_we = 1'b1;
    sync();
    dbg_we = 1'b0;
  endtask

  task automatic dread_chk(int r, int i, string req);
    dbg_reg = 3'(r); dbg_idx = 5'(i); #1;
    chk(dbg_rdata === gold[r][i], req, dbg_rdata, gold[r][i]);
  endtask

  task automatic check_all(string req);
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 32; i++) dread_chk(r, i, req);
    sync();
  endtask

  task automatic wait_idle();
    while (busy) sync();
  endtask

  task automatic issue(bit op, int vd, int vs1, int vs2, int vl, output int acc);
    logic [31:0] tmp [32];
    issue_valid = 1'b1; issue_op = op;
    issue_vd = 3'(vd); issue_vs1 = 3'(vs1); issue_vs2 = 3'(vs2); issue_vl = 6'(vl);
    #1;
    while (!issue_ready) sync();
    acc = cyc;
    for (int i = 0; i < vl; i++) tmp[i] = alu(op, gold[vs1][i], gold[vs2][i]);
    for (int i = 0; i < vl; i++) gold[vd][i] = tmp[i];
    sync();
    issue_valid = 1'b0;
  endtask

  int a1, a2, nd0;
  logic [31:0] keep;

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = 1'b0;
    issue_vd = '0; issue_vs1 = '0; issue_vs2 = '0; issue_vl = 6'd1;
    dbg_we = 1'b0; dbg_reg = '0; dbg_idx = '0; dbg_wdata = '0;
    repeat (2) @(negedge clk);
    #1;
    chk(issue_ready === 1'b1, "R10 ready in reset", 32'(issue_ready), 1);
    chk(busy === 1'b0, "R10 busy in reset", 32'(busy), 0);
    chk(done === 1'b0, "R10 done in reset", 32'(done), 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(issue_ready === 1'b1 && busy === 1'b0 && done === 1'b0,
        "R10 state after release", {29'd0, issue_ready, busy, done}, 32'h4);

    // R1: load every element through the debug port and read it back
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 32; i++) begin
        gold[r][i] = $urandom;
        dwrite(r, i, gold[r][i]);
      end
    check_all("R1 debug load");

    // R3: wrap-around add on a full-length vector, R5 latency (8 rows + 2)
    gold[1][0] = 32'hFFFF_FFFF; dwrite(1, 0, gold[1][0]);
    gold[2][0] = 32'h0000_0001; dwrite(2, 0, gold[2][0]);
    gold[1][1] = 32'h8000_0000; dwrite(1, 1, gold[1][1]);
    gold[2][1] = 32'h8000_0000; dwrite(2, 1, gold[2][1]);
    issue(1'b0, 3, 1, 2, 32, a1);
    wait_idle();
    chk(last_done == a1 + 1 + 8 + 2, "R5 add vl=32 done cycle", 32'(last_done), 32'(a1 + 11));
    dread_chk(3, 0, "R3 wrap to zero");
    dread_chk(3, 1, "R3 carry lost");
    check_all("R3 add result");

    // R4 + R2: partial multiply (vl=5), -1*-1 low bits, R5 latency (2 rows + 6)
    gold[1][2] = 32'hFFFF_FFFF; dwrite(1, 2, gold[1][2]);
    gold[2][2] = 32'hFFFF_FFFF; dwrite(2, 2, gold[2][2]);
    keep = gold[4][5];
    issue(1'b1, 4, 1, 2, 5, a1);
    wait_idle();
    chk(last_done == a1 + 1 + 2 + 6, "R5 mul vl=5 done cycle", 32'(last_done), 32'(a1 + 9));
    dread_chk(4, 2, "R4 low product bits");
    dread_chk(4, 5, "R2 element past vl kept");
    chk(gold[4][5] === keep, "R2 model element past vl", gold[4][5], keep);
    check_all("R2 partial length");

    // R2/R5: single-element add, 1 row + 2
    issue(1'b0, 5, 0, 0, 1, a1);
    wait_idle();
    chk(last_done == a1 + 1 + 1 + 2, "R5 add vl=1 done cycle", 32'(last_done), 32'(a1 + 4));
    check_all("R2 vl=1");

    // R6: read-after-write dependency held until the writer's done
    issue(1'b1, 6, 1, 2, 8, a1);
    issue(1'b0, 7, 6, 0, 32, a2);
    chk(a2 == last_done, "R6 dependent accept in writer done cycle", 32'(a2), 32'(last_done));
    chk(a2 == a1 + 1 + 2 + 6, "R6 dependent accept cycle", 32'(a2), 32'(a1 + 9));
    wait_idle();
    check_all("R6 program order");

    // R7: independent multiplies overlap
    issue(1'b1, 3, 1, 2, 4, a1);
    issue(1'b1, 5, 0, 4, 4, a2);
    chk(a2 == a1 + 2, "R7 overlapped accept", 32'(a2), 32'(a1 + 2));
    wait_idle();
    check_all("R7 overlapped results");

    // R8: add behind a multiply waits for the write-back order
    issue(1'b1, 6, 1, 3, 4, a1);
    issue(1'b0, 2, 0, 1, 4, a2);
    chk(a2 >= a1 + 6, "R8 add held behind multiply", 32'(a2), 32'(a1 + 6));
    wait_idle();
    check_all("R8 both results intact");

    // R11 + R9: debug write during a long multiply is ignored
    issue(1'b1, 4, 1, 0, 32, a1);
    chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 1);
    dwrite(7, 0, ~gold[7][0]);
    wait_idle();
    dread_chk(7, 0, "R11 write while busy ignored");
    check_all("R11 register file");

    // R4/R9: random stream issued as fast as the interlock permits
    nd0 = ndone;
    for (int n = 0; n < 60; n++) begin
      issue(1'($urandom), int'($urandom % 8), int'($urandom % 8),
            int'($urandom % 8), int'($urandom % 32) + 1, a1);
    end
    wait_idle();
    sync();
    chk(ndone - nd0 == 60, "R9 one done per instruction", 32'(ndone - nd0), 60);
    chk(done === 1'b0, "R9 done low when idle", 32'(done), 0);
    check_all("R4 random stream");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule